// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block captures audio from an external converter that drives the bit clock, the word-select (frame) clock and the serial data line. The receiver is a pure slave. It oversamples all three lines in its own system clock domain, so the system clock must run at least four times faster than the bit clock. At a 96 kHz frame rate the bit clock is 64 × 96 kHz = 6.144 MHz, so any system clock of about 25 MHz or more is enough.

Two frame formats can be chosen while the block runs:

- **Standard I2S.** A frame starts when word-select falls. The data lags the word-select edge by one bit clock.
- **Left-justified.** A frame starts when word-select rises. The data is aligned with the edge, and the width of the word-select high pulse does not matter.

A separate control inverts word-select before edge detection, so either format can accept the opposite framing edge.

Each frame holds two 32-bit slots. The first slot is the left channel and the second is the right channel. The top 24 bits of each slot are a two's-complement sample, sent MSB first. The low 8 bits are padding and are discarded. Each sample leaves the block sign-extended to 32 bits, with a one-cycle valid pulse and a channel tag. A mono option passes only one chosen channel, giving one result per frame. Capture begins only at a detected frame start. This applies after reset and after any change of format or inversion, so a partial frame is never reported.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `smp_valid_o` is 0 and `smp_data_o` is 0.
- R2: With `fmt_lj_i`=0 (I2S), a frame starts on a falling edge of the effective word-select. The left sample's MSB is the bit sampled on the next bit-clock rising edge, and the right slot follows 32 bit clocks later. Alignment must be exact: a value is never reported doubled or halved.
- R3: With `fmt_lj_i`=1 (left-justified), a frame starts on a rising edge of the effective word-select. The left sample's MSB is the bit sampled on that same bit-clock rising edge. This holds for any high-pulse width from 1 to 32 bit clocks.
- R4: The effective word-select is `ws_i` XOR `ws_inv_i`. Setting `ws_inv_i`=1 makes each format accept the opposite raw edge of `ws_i` as its frame start.
- R5: Bits 0 to 23 of a slot, counted from the slot start, are the sample with the MSB first. Slot bits 24 to 31 have no effect on any output, even when they are driven to 1.
- R6: `smp_data_o[31:24]` always equals `smp_data_o[23]`. For example, the sample 0x800000 is reported as 0xFF800000.
- R7: With `mono_en_i`=0, each frame yields two results: the left one first with `smp_chan_o`=0, then the right one with `smp_chan_o`=1. Each result is marked by a `smp_valid_o` pulse that lasts one cycle and follows a bit-clock rising edge.
- R8: With `mono_en_i`=1, each frame yields exactly one result. It is the channel given by `mono_sel_i` (0 = left, 1 = right), and `smp_chan_o` equals `mono_sel_i`.
- R9: After reset, the block produces nothing until it detects a frame start. Any bits that arrive before that frame start are discarded.
- R10: A change of `fmt_lj_i` or `ws_inv_i` discards the frame in progress, including its slots that are not yet finished. Capture resumes at the next detected frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4× the bit clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Bit clock from the external master |
| ws_i | input | 1 | Word-select / frame clock from the external master |
| sd_i | input | 1 | Serial data, sampled on bit-clock rising edges |
| fmt_lj_i | input | 1 | Frame format: 0 = I2S, 1 = left-justified |
| ws_inv_i | input | 1 | 1 = invert word-select before edge detection |
| mono_en_i | input | 1 | 1 = report only one channel per frame |
| mono_sel_i | input | 1 | Channel kept in mono mode: 0 = left, 1 = right |
| smp_valid_o | output | 1 | One-cycle pulse marking a new sample |
| smp_chan_o | output | 1 | Channel of the sample: 0 = left, 1 = right |
| smp_data_o | output | 32 | 24-bit sample sign-extended to 32 bits |

## Verification
Two events can fall on the same bit-clock edge.

- **Left-justified format.** Frame-start detection and the capture of the left sample's MSB happen on one edge. If the receiver handles them in separate cycles, every sample comes out doubled or halved. The bench uses samples whose two top bits differ, such as 0x400000 and 0x800000, so that any shift of one position changes the value or the sign.
- **I2S format.** The last padding bit of one frame arrives on the same edge that detects the next frame start. The bench drives ones in all padding bits, so a padding bit that leaks into the next sample changes its value.

A third collision is a configuration change in the middle of a frame. The bench toggles the inversion control after the left sample has been reported. It then expects the right sample of that frame to be lost and the following frame to be captured in full.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    localparam int SARX_SLOT_BITS   = 32;
    localparam int SARX_DATA_BITS   = 24;
    localparam int SARX_OUT_BITS    = 32;
    localparam int SARX_SYNC_STAGES = 2;

    // Frame format selector
    typedef enum logic {
        FMT_I2S   = 1'b0,
        FMT_LEFTJ = 1'b1
    } sarx_fmt_e;

endpackage

// File: rtl/sarx_sync.sv
// Multi-stage synchroniser for a bundle of slow asynchronous lines.
// All lines see the same latency, so their relative timing is kept.
module sarx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;
    logic [STAGES-1:0][WIDTH-1:0] pipe_d;

    // Each stage takes the value of the stage before it; stage 0 takes the raw lines.
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign pipe_d[s] = async_i;
            end else begin : g_next
                assign pipe_d[s] = pipe_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/sarx_framer.sv
// Frame-start detection, slot/bit counting and sample assembly.
// Works on the synchronised lines. A bit is taken on each detected rising edge of the bit clock.
module sarx_framer
    import sarx_pkg::*;
#(
    parameter int SLOT_BITS = SARX_SLOT_BITS,
    parameter int DATA_BITS = SARX_DATA_BITS
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 bclk_s_i,
    input  logic                 ws_s_i,
    input  logic                 sd_s_i,
    input  sarx_fmt_e            fmt_i,
    input  logic                 ws_inv_i,
    output logic                 evt_hit_o,
    output logic                 evt_chan_o,
    output logic [DATA_BITS-1:0] evt_smp_o
);

    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int SB_W       = $clog2(SLOT_BITS);
    localparam logic [SB_W-1:0]  LAST_POS = SB_W'(DATA_BITS - 1);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    typedef struct packed {
        logic                 bclk_prev;
        logic                 ws_prev;     // raw word-select at the previous bit-clock rise
        logic                 prev_ok;     // ws_prev holds a real sample
        logic                 armed;       // a frame start has been seen
        logic [CNT_W-1:0]     cnt;         // position of the next bit within the frame
        logic [DATA_BITS-1:0] shreg;
        logic                 fmt_q;
        logic                 inv_q;
        logic                 evt_hit;
        logic                 evt_chan;
        logic [DATA_BITS-1:0] evt_smp;
    } fr_state_t;

    fr_state_t st_d, st_q;

    logic             lj_mode;
    logic             cfg_chg;
    logic             bclk_rise;
    logic             ws_cur_e;
    logic             ws_prev_e;
    logic             frame_start;
    logic             take_bit;
    logic [CNT_W-1:0] pos;
    logic [SB_W-1:0]  slot_pos;

    always_comb begin
        lj_mode   = (fmt_i == FMT_LEFTJ);
        cfg_chg   = (lj_mode != st_q.fmt_q) || (ws_inv_i != st_q.inv_q);
        bclk_rise = bclk_s_i & ~st_q.bclk_prev;
        ws_cur_e  = ws_s_i ^ ws_inv_i;
        ws_prev_e = st_q.ws_prev ^ ws_inv_i;

        // Left-justified frames start on a rising edge, I2S frames on a falling edge.
        if (lj_mode) begin
            frame_start = bclk_rise & st_q.prev_ok & ws_cur_e & ~ws_prev_e;
        end else begin
            frame_start = bclk_rise & st_q.prev_ok & ~ws_cur_e & ws_prev_e;
        end

        // Left-justified takes bit 0 on the start edge itself; I2S waits one bit clock.
        take_bit = bclk_rise & (frame_start ? lj_mode : st_q.armed);
        pos      = frame_start ? '0 : st_q.cnt;
        slot_pos = pos[SB_W-1:0];

        st_d           = st_q;
        st_d.evt_hit   = 1'b0;
        st_d.bclk_prev = bclk_s_i;
        st_d.fmt_q     = lj_mode;
        st_d.inv_q     = ws_inv_i;

        if (bclk_rise) begin
            st_d.ws_prev = ws_s_i;
            st_d.prev_ok = 1'b1;
        end

        if (frame_start) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end

        if (take_bit) begin
            st_d.cnt = pos + ONE_CNT;
            if (slot_pos <= LAST_POS) begin
                st_d.shreg = {st_q.shreg[DATA_BITS-2:0], sd_s_i};
            end
            if (slot_pos == LAST_POS) begin
                st_d.evt_hit  = 1'b1;
                st_d.evt_chan = pos[CNT_W-1];
                st_d.evt_smp  = {st_q.shreg[DATA_BITS-2:0], sd_s_i};
            end
        end

        // A format or polarity change drops the current frame.
        if (cfg_chg) begin
            st_d.armed   = 1'b0;
            st_d.evt_hit = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_hit_o  = st_q.evt_hit;
    assign evt_chan_o = st_q.evt_chan;
    assign evt_smp_o  = st_q.evt_smp;

endmodule

// File: rtl/sarx_outsel.sv
// Channel filter (stereo or one chosen channel) and sign-extending output register.
module sarx_outsel #(
    parameter int DATA_BITS = 24,
    parameter int OUT_BITS  = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 evt_hit_i,
    input  logic                 evt_chan_i,
    input  logic [DATA_BITS-1:0] evt_smp_i,
    input  logic                 mono_en_i,
    input  logic                 mono_sel_i,
    output logic                 valid_o,
    output logic                 chan_o,
    output logic [OUT_BITS-1:0]  data_o
);

    localparam int EXT_BITS = OUT_BITS - DATA_BITS;

    typedef struct packed {
        logic                valid;
        logic                chan;
        logic [OUT_BITS-1:0] data;
    } os_state_t;

    os_state_t os_d, os_q;
    logic      keep;

    always_comb begin
        keep       = evt_hit_i & (~mono_en_i | (evt_chan_i == mono_sel_i));
        os_d       = os_q;
        os_d.valid = keep;
        if (keep) begin
            os_d.chan = evt_chan_i;
            os_d.data = {{EXT_BITS{evt_smp_i[DATA_BITS-1]}}, evt_smp_i};
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign valid_o = os_q.valid;
    assign chan_o  = os_q.chan;
    assign data_o  = os_q.data;

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int SLOT_BITS   = SARX_SLOT_BITS,
    parameter int DATA_BITS   = SARX_DATA_BITS,
    parameter int OUT_BITS    = SARX_OUT_BITS,
    parameter int SYNC_STAGES = SARX_SYNC_STAGES
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bclk_i,
    input  logic                ws_i,
    input  logic                sd_i,
    input  logic                fmt_lj_i,
    input  logic                ws_inv_i,
    input  logic                mono_en_i,
    input  logic                mono_sel_i,
    output logic                smp_valid_o,
    output logic                smp_chan_o,
    output logic [OUT_BITS-1:0] smp_data_o
);

    logic [2:0]           line_s;
    logic                 evt_hit;
    logic                 evt_chan;
    logic [DATA_BITS-1:0] evt_smp;
    sarx_fmt_e            fmt;

    assign fmt = sarx_fmt_e'(fmt_lj_i);

    sarx_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({bclk_i, ws_i, sd_i}),
        .sync_o  (line_s)
    );

    sarx_framer #(
        .SLOT_BITS (SLOT_BITS),
        .DATA_BITS (DATA_BITS)
    ) u_framer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bclk_s_i   (line_s[2]),
        .ws_s_i     (line_s[1]),
        .sd_s_i     (line_s[0]),
        .fmt_i      (fmt),
        .ws_inv_i   (ws_inv_i),
        .evt_hit_o  (evt_hit),
        .evt_chan_o (evt_chan),
        .evt_smp_o  (evt_smp)
    );

    sarx_outsel #(
        .DATA_BITS (DATA_BITS),
        .OUT_BITS  (OUT_BITS)
    ) u_outsel (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .evt_hit_i  (evt_hit),
        .evt_chan_i (evt_chan),
        .evt_smp_i  (evt_smp),
        .mono_en_i  (mono_en_i),
        .mono_sel_i (mono_sel_i),
        .valid_o    (smp_valid_o),
        .chan_o     (smp_chan_o),
        .data_o     (smp_data_o)
    );

endmodule

// File: rtl/sarx_checker.sv
module sarx_checker #(
    parameter int DATA_BITS = 24,
    parameter int OUT_BITS  = 32
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                bclk_i,
    input logic                mono_en_i,
    input logic                mono_sel_i,
    input logic                smp_valid_o,
    input logic                smp_chan_o,
    input logic [OUT_BITS-1:0] smp_data_o
);

    // Cycles since the last raw bit-clock rise (saturating).
    logic [3:0] since_rise_q;
    logic       bclk_prev_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            since_rise_q <= 4'hF;
            bclk_prev_q  <= 1'b0;
        end else begin
            bclk_prev_q <= bclk_i;
            if (bclk_i && !bclk_prev_q) begin
                since_rise_q <= 4'd0;
            end else if (since_rise_q != 4'hF) begin
                since_rise_q <= since_rise_q + 4'd1;
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_valid_o |=> !smp_valid_o); // R7

    AST_SIGN_EXTENDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_valid_o |-> (smp_data_o[OUT_BITS-1:DATA_BITS] == {(OUT_BITS-DATA_BITS){smp_data_o[DATA_BITS-1]}})); // R6

    AST_MONO_CHANNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_valid_o && mono_en_i && $stable(mono_en_i) && $stable(mono_sel_i)) |-> (smp_chan_o == mono_sel_i)); // R8

    AST_VALID_AFTER_BCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_valid_o |-> (since_rise_q < 4'd9)); // R7

endmodule

bind serial_audio_rx sarx_checker #(
    .DATA_BITS (DATA_BITS),
    .OUT_BITS  (OUT_BITS)
) u_sarx_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bclk_i      (bclk_i),
    .mono_en_i   (mono_en_i),
    .mono_sel_i  (mono_sel_i),
    .smp_valid_o (smp_valid_o),
    .smp_chan_o  (smp_chan_o),
    .smp_data_o  (smp_data_o)
);

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BCLK  = 4;   // system cycles per bit-clock half period

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        bclk_i = 1'b0;
    logic        ws_i = 1'b0;
    logic        sd_i = 1'b0;
    logic        fmt_lj_i = 1'b0;
    logic        ws_inv_i = 1'b0;
    logic        mono_en_i = 1'b0;
    logic        mono_sel_i = 1'b0;
    logic        smp_valid_o;
    logic        smp_chan_o;
    logic [31:0] smp_data_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        chan;
        logic [31:0] data;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    serial_audio_rx uut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bclk_i      (bclk_i),
        .ws_i        (ws_i),
        .sd_i        (sd_i),
        .fmt_lj_i    (fmt_lj_i),
        .ws_inv_i    (ws_inv_i),
        .mono_en_i   (mono_en_i),
        .mono_sel_i  (mono_sel_i),
        .smp_valid_o (smp_valid_o),
        .smp_chan_o  (smp_chan_o),
        .smp_data_o  (smp_data_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    // Monitor: pop one expected item for each result and compare
    always @(negedge clk_i) begin
        if (rst_ni && smp_valid_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9/R10: unexpected sample chan=%0d data=%h, expected none", smp_chan_o, smp_data_o);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (smp_chan_o !== e.chan || smp_data_o !== e.data) begin
                    errors++;
                    $display("FAIL %s: got chan=%0d data=%h, expected chan=%0d data=%h",
                             e.req, smp_chan_o, smp_data_o, e.chan, e.data);
                end
            end
        end
    end

    function automatic logic [31:0] sext(input logic [23:0] v);
        return {{8{v[23]}}, v};
    endfunction

    task automatic push_exp(input logic ch, input logic [23:0] v, input string req);
        exp_t e;
        e.chan = ch;
        e.data = sext(v);
        e.req  = req;
        exp_q.push_back(e);
    endtask

    // One bit-clock period: lines change while the bit clock is low
    task automatic bit_period(input logic ws_eff, input logic sd);
        bclk_i = 1'b0;
        ws_i   = ws_eff ^ ws_inv_i;
        sd_i   = sd;
        repeat (HALF_BCLK) @(negedge clk_i);
        bclk_i = 1'b1;
        repeat (HALF_BCLK) @(negedge clk_i);
    endtask

    // Idle periods with word-select held at the level before a frame start
    task automatic preamble(input int n);
        for (int i = 0; i < n; i++) begin
            bit_period(fmt_lj_i ? 1'b0 : 1'b1, 1'b0);
        end
    endtask

    // One frame. Padding is driven as ones (R5). A toggle of the polarity control
    // before period glitch_at discards the rest of the frame (R10).
    task automatic send_frame(input logic [23:0] l, input logic [23:0] r,
                              input int pulse, input int glitch_at,
                              input bit keep_r, input string req);
        logic [63:0] fr;
        logic        wse;
        logic        sd;
        fr = {l, 8'hFF, r, 8'hFF};
        if (mono_en_i) begin
            if (!mono_sel_i) push_exp(1'b0, l, {req, "/R8"});
            else if (keep_r) push_exp(1'b1, r, {req, "/R8"});
        end else begin
            push_exp(1'b0, l, {req, "/R7"});
            if (keep_r) push_exp(1'b1, r, {req, "/R7"});
        end
        for (int b = 0; b < 64; b++) begin
            if (b == glitch_at) begin
                ws_inv_i = ~ws_inv_i;
                repeat (2) @(negedge clk_i);
                ws_inv_i = ~ws_inv_i;
            end
            if (fmt_lj_i) begin
                wse = (b < pulse);
                sd  = fr[63-b];
            end else begin
                wse = (b >= 32);
                sd  = (b == 0) ? 1'b1 : fr[64-b];
            end
            bit_period(wse, sd);
        end
    endtask

    task automatic set_cfg(input logic lj, input logic inv, input logic mono, input logic sel);
        fmt_lj_i   = lj;
        ws_inv_i   = inv;
        mono_en_i  = mono;
        mono_sel_i = sel;
        repeat (4) @(negedge clk_i);
        preamble(3);
    endtask

    task automatic std_frames(input int pulse, input string req);
        send_frame(24'h400000, 24'hC00001, pulse, -1, 1'b1, req);
        send_frame(24'h7FFFFF, 24'h800000, pulse, -1, 1'b1, req);
        send_frame(24'h123456, 24'h000000, pulse, -1, 1'b1, req);
        send_frame(24'hFEDCBA, 24'h000001, pulse, -1, 1'b1, req);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk_i);
        // R1: reset state
        checks++;
        if (smp_valid_o !== 1'b0 || smp_data_o !== 32'h0) begin
            errors++;
            $display("FAIL R1: got valid=%b data=%h, expected 0/00000000", smp_valid_o, smp_data_o);
        end
        rst_ni = 1'b1;
        @(negedge clk_i);
        checks++;
        if (smp_valid_o !== 1'b0 || smp_data_o !== 32'h0) begin
            errors++;
            $display("FAIL R1: got valid=%b data=%h after release, expected 0/00000000",
                     smp_valid_o, smp_data_o);
        end

        // R9: partial frame after reset (I2S, low half then high half) is discarded
        for (int i = 0; i < 20; i++) bit_period(1'b0, 1'b1);
        for (int i = 0; i < 32; i++) bit_period(1'b1, 1'b1);

        // R2: I2S, one-bit delay, exact alignment
        std_frames(0, "R2");

        // R3: left-justified, single-period pulse and wide pulse
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        std_frames(1, "R3");
        send_frame(24'h400000, 24'h800000, 32, -1, 1'b1, "R3");

        // R4: inverted word-select in both formats
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0);
        send_frame(24'h654321, 24'hABCDEF, 5, -1, 1'b1, "R4");
        set_cfg(1'b0, 1'b1, 1'b0, 1'b0);
        send_frame(24'h0F0F0F, 24'hF0F0F0, 0, -1, 1'b1, "R4");
        send_frame(24'h400000, 24'h800000, 0, -1, 1'b1, "R4");

        // R8: mono, right channel in left-justified, left channel in I2S
        set_cfg(1'b1, 1'b0, 1'b1, 1'b1);
        send_frame(24'h111111, 24'hC00001, 1, -1, 1'b1, "R8");
        send_frame(24'h222222, 24'h7FFFFF, 1, -1, 1'b1, "R8");
        set_cfg(1'b0, 1'b0, 1'b1, 1'b0);
        send_frame(24'h800000, 24'h333333, 0, -1, 1'b1, "R8");
        send_frame(24'h400000, 24'h444444, 0, -1, 1'b1, "R8");

        // R10: polarity toggle mid-frame drops the right slot; next frame is whole
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        send_frame(24'h135790, 24'h2468AC, 1, 40, 1'b0, "R10");
        send_frame(24'hA5A5A5, 24'h5A5A5A, 1, -1, 1'b1, "R10");

        preamble(4);
        repeat (10) @(negedge clk_i);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R7: got %0d samples missing, expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule